// File: doc/BRIEF.md
# Two-Beat Quad-Data-Rate Static Memory Model

This block is a synthesizable behavioural model of a static memory with a write port and a read port that run at the same time and share one address bus. Every access moves a fixed burst of two words at double data rate. The model runs on one internal clock at twice the K rate. A phase bit marks which internal edge stands for the K rising edge and which stands for the K# rising edge. The first edge after reset is always a K rising edge.

A write begins when the active-low write select is low at a K rising edge. The address and the first data beat are taken at that edge, and the second beat is taken at the following K# edge. Each beat carries its own active-low lane masks. One address selects a pair of words held in two arrays: beat 0 goes to the first array and beat 1 to the second. A read begins when the active-low read select is low at a K rising edge. It returns the stored pair as two consecutive half-cycle beats, with an output-enable flag standing in for the pad three-state control. A free-running echo clock marks the output beat timing.

A static mode input picks the output reference. With `k_only` high, read data is launched from the K edges. With `k_only` low, it is launched from a separate output clock that lags K by a fixed number of half-cycles.

Top module: `qdr_b2_sram`

## Requirements
- R1: While reset is high, and after it is released until a read completes, `rdata_oe` is 0 and `rdata` is 0. A read whose data has not yet been launched when reset rises produces no output.
- R2: A write burst stores the K-rising beat and the K#-rising beat as the pair at the sampled address. With `k_only`=1, a read sampled at internal edge e drives word 0 on `rdata` after edge e+3 and word 1 after edge e+4, with `rdata_oe`=1 for both (edge 0 is the first edge after reset).
- R3: `wmask_n` bit i, active low, enables lane i, which covers data bits [(i+1)*LANE_W-1 : i*LANE_W] (LANE_W = DATA_W/LANES). Each beat uses the mask present on its own edge. Lanes with mask 1 keep their old contents.
- R4: With `wr_sel_n` high at a K rising edge, no write takes place, whatever is on `wdata`, `wmask_n` and `addr`.
- R5: With `rd_sel_n` high at a K rising edge, no read output is produced: `rdata_oe` stays 0 where that read's beats would have been.
- R6: A read and a write sampled at the same K rising edge return the newly written data, merged lane by lane with the old contents according to both beats' masks.
- R7: Reads on consecutive K cycles give a continuous stream of beats with `rdata_oe` held high across the burst boundary.
- R8: After the last burst of a read stream, `rdata_oe` falls at the edge right after word 1 (edge e+L+2 for a read at edge e with launch delay L).
- R9: With `k_only`=0, the launch delay becomes L = RD_LAT_HALF + C_SKEW_HALF half-cycles (5 by default) in place of RD_LAT_HALF (3).
- R10: `echo_clk` toggles at every internal edge. After edge t it is 1 exactly when t and the current launch delay L have the same parity, so it is high during every word-0 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate |
| rst | input | 1 | Synchronous active-high reset |
| k_only | input | 1 | 1: launch read data from K; 0: from the lagging output clock (static; change only in reset) |
| wr_sel_n | input | 1 | Active-low write select, sampled at K rising |
| rd_sel_n | input | 1 | Active-low read select, sampled at K rising |
| addr | input | ADDR_W | Shared pair address, sampled at K rising |
| wdata | input | DATA_W | Write data, one beat per internal edge |
| wmask_n | input | LANES | Active-low lane enables for the current beat |
| rdata | output | DATA_W | Read data beats, 0 when idle |
| rdata_oe | output | 1 | High while a read beat is driven |
| echo_clk | output | 1 | Free-running echo of the launch clock |

## Verification
The bench goes after a read and a write in the same K cycle with crossed lane masks. A model without forwarding would return the stale pair there, and one that merged with the wrong beat's mask would corrupt a single lane. It drives garbage data with the write port deselected, which catches a design that writes regardless of the select. It checks the exact edge where `rdata_oe` falls after a stream and stays high between back-to-back bursts, which exposes an off-by-one in the serializer. It also reruns the traffic with the separate output clock, where a wrong tap in the delay line would shift both the data and the echo parity.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Fewest half-cycles from a read command to its first output beat:
  // sample, array read with forwarding, merge, then the output register.
  localparam int QDR_MIN_LAT_HALF = 3;

  function automatic int launch_tap(input int rd_lat_half, input int skew_half,
                                    input bit use_k);
    launch_tap = rd_lat_half - QDR_MIN_LAT_HALF + (use_k ? 0 : skew_half);
  endfunction
endpackage

// File: rtl/qdr_phase_gen.sv
module qdr_phase_gen #(
  parameter int RD_LAT_HALF = 3,
  parameter int C_SKEW_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic k_only,
  output logic ph,        // 0: this edge is K rising, 1: K# rising
  output logic echo_clk
);
  localparam logic PAR_K = 1'((RD_LAT_HALF) % 2);
  localparam logic PAR_C = 1'((RD_LAT_HALF + C_SKEW_HALF) % 2);

  logic started;
  logic par;

  assign par = k_only ? PAR_K : PAR_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 1'b0;
      echo_clk <= 1'b0;
      started  <= 1'b0;
    end else begin
      ph       <= ~ph;
      echo_clk <= (ph == par);
      started  <= 1'b1;
    end
  end

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ph != $past(ph)));  // R10

  AST_ECHO_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (started && $stable(k_only)) |=> (echo_clk != $past(echo_clk)));  // R10
endmodule

// File: rtl/qdr_cmd_capture.sv
module qdr_cmd_capture #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph,
  input  logic              wr_sel_n,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wmask_n,
  output logic              cmd_wr,    // high during the K# half of a write
  output logic              cmd_rd,    // high during the K# half of a read
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] beat0_d,
  output logic [LANES-1:0]  beat0_en,
  output logic [DATA_W-1:0] beat1_d,
  output logic [LANES-1:0]  beat1_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_wr <= 1'b0;
      cmd_rd <= 1'b0;
    end else begin
      cmd_wr <= ~ph & ~wr_sel_n;
      cmd_rd <= ~ph & ~rd_sel_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_addr <= '0;
      beat0_d  <= '0;
      beat0_en <= '0;
    end else if (!ph) begin
      cmd_addr <= addr;
      beat0_d  <= wdata;
      beat0_en <= ~wmask_n;
    end
  end

  // The second beat is used directly on the K# edge that follows.
  assign beat1_d  = wdata;
  assign beat1_en = ~wmask_n;

  AST_WR_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ph && wr_sel_n) |=> !cmd_wr);  // R4

  AST_RD_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ph && rd_sel_n) |=> !cmd_rd);  // R5

  AST_CMD_ON_KBAR_HALF: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr || cmd_rd) |-> ph);  // R2
endmodule

// File: rtl/qdr_pair_array.sv
module qdr_pair_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd0,
  input  logic [LANES-1:0]  wen0,
  input  logic [DATA_W-1:0] wd1,
  input  logic [LANES-1:0]  wen1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [1:0][DATA_W-1:0] wd_pk;
  logic [1:0][LANES-1:0]  wen_pk;
  logic [1:0][DATA_W-1:0] rd_pk;

  assign wd_pk  = {wd1, wd0};
  assign wen_pk = {wen1, wen0};
  assign rd0    = rd_pk[0];
  assign rd1    = rd_pk[1];

  // One narrow read-first memory per bank and lane, so each maps to a
  // plain block RAM without byte-enable support.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rq;

      always_ff @(posedge clk) begin
        if (wr_en && wen_pk[b][l])
          mem[addr] <= wd_pk[b][l*LANE_W +: LANE_W];
        if (rd_en)
          rq <= mem[addr];
      end

      assign rd_pk[b][l*LANE_W +: LANE_W] = rq;
    end
  end
endmodule

// File: rtl/qdr_read_path.sv
module qdr_read_path
  import qdr_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int LANES       = 2,
  parameter int RD_LAT_HALF = 3,
  parameter int C_SKEW_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_only,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] beat0_d,
  input  logic [LANES-1:0]  beat0_en,
  input  logic [DATA_W-1:0] beat1_d,
  input  logic [LANES-1:0]  beat1_en,
  input  logic [DATA_W-1:0] arr0,
  input  logic [DATA_W-1:0] arr1,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int TAP_K  = launch_tap(RD_LAT_HALF, C_SKEW_HALF, 1'b1);
  localparam int TAP_C  = launch_tap(RD_LAT_HALF, C_SKEW_HALF, 1'b0);
  localparam int NSTG   = TAP_C + 1;

  // Forwarding state captured with the array read.
  logic              rd_s2;
  logic              fwd_wr;
  logic [DATA_W-1:0] fwd_d0, fwd_d1;
  logic [LANES-1:0]  fwd_m0, fwd_m1;
  logic [DATA_W-1:0] mrg0, mrg1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s2  <= 1'b0;
      fwd_wr <= 1'b0;
      fwd_d0 <= '0;
      fwd_d1 <= '0;
      fwd_m0 <= '0;
      fwd_m1 <= '0;
    end else begin
      rd_s2  <= cmd_rd;
      fwd_wr <= cmd_wr & cmd_rd;
      fwd_d0 <= beat0_d;
      fwd_d1 <= beat1_d;
      fwd_m0 <= beat0_en;
      fwd_m1 <= beat1_en;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign mrg0[l*LANE_W +: LANE_W] = (fwd_wr && fwd_m0[l]) ?
      fwd_d0[l*LANE_W +: LANE_W] : arr0[l*LANE_W +: LANE_W];
    assign mrg1[l*LANE_W +: LANE_W] = (fwd_wr && fwd_m1[l]) ?
      fwd_d1[l*LANE_W +: LANE_W] : arr1[l*LANE_W +: LANE_W];
  end

  // Stage 0 holds the merged pair; further stages delay it by half-cycles
  // to reach the chosen launch reference.
  logic              st_vld [NSTG];
  logic [DATA_W-1:0] st_w0  [NSTG];
  logic [DATA_W-1:0] st_w1  [NSTG];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld[0] <= 1'b0;
      st_w0[0]  <= '0;
      st_w1[0]  <= '0;
    end else begin
      st_vld[0] <= rd_s2;
      st_w0[0]  <= mrg0;
      st_w1[0]  <= mrg1;
    end
  end

  for (genvar i = 1; i < NSTG; i++) begin : g_delay
    always_ff @(posedge clk) begin
      if (rst) begin
        st_vld[i] <= 1'b0;
        st_w0[i]  <= '0;
        st_w1[i]  <= '0;
      end else begin
        st_vld[i] <= st_vld[i-1];
        st_w0[i]  <= st_w0[i-1];
        st_w1[i]  <= st_w1[i-1];
      end
    end
  end

  logic              tap_vld;
  logic [DATA_W-1:0] tap_w0, tap_w1;

  assign tap_vld = k_only ? st_vld[TAP_K] : st_vld[TAP_C];
  assign tap_w0  = k_only ? st_w0[TAP_K]  : st_w0[TAP_C];
  assign tap_w1  = k_only ? st_w1[TAP_K]  : st_w1[TAP_C];

  // Two-beat serializer.
  logic              pend;
  logic [DATA_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
      pend     <= 1'b0;
      hold     <= '0;
    end else if (tap_vld) begin
      rdata    <= tap_w0;
      rdata_oe <= 1'b1;
      pend     <= 1'b1;
      hold     <= tap_w1;
    end else if (pend) begin
      rdata    <= hold;
      rdata_oe <= 1'b1;
      pend     <= 1'b0;
    end else begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end
  end

  AST_BEATS_IN_PAIRS: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |=> rdata_oe);  // R2

  AST_OE_FALL_AFTER_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(rdata_oe) |-> $past(rdata_oe, 2));  // R8

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata == '0));  // R1
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 18,
  parameter int LANES       = 2,
  parameter int RD_LAT_HALF = 3,
  parameter int C_SKEW_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              k_only,
  input  logic              wr_sel_n,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wmask_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              echo_clk
);
  logic              ph;
  logic              cmd_wr, cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] b0_d, b1_d, arr0, arr1;
  logic [LANES-1:0]  b0_en, b1_en;

  qdr_phase_gen #(
    .RD_LAT_HALF(RD_LAT_HALF), .C_SKEW_HALF(C_SKEW_HALF)
  ) u_phase (
    .clk(clk), .rst(rst), .k_only(k_only), .ph(ph), .echo_clk(echo_clk)
  );

  qdr_cmd_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_cap (
    .clk(clk), .rst(rst), .ph(ph),
    .wr_sel_n(wr_sel_n), .rd_sel_n(rd_sel_n), .addr(addr),
    .wdata(wdata), .wmask_n(wmask_n),
    .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .beat0_d(b0_d), .beat0_en(b0_en), .beat1_d(b1_d), .beat1_en(b1_en)
  );

  qdr_pair_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_arr (
    .clk(clk), .wr_en(cmd_wr), .rd_en(cmd_rd), .addr(cmd_addr),
    .wd0(b0_d), .wen0(b0_en), .wd1(b1_d), .wen1(b1_en),
    .rd0(arr0), .rd1(arr1)
  );

  qdr_read_path #(
    .DATA_W(DATA_W), .LANES(LANES),
    .RD_LAT_HALF(RD_LAT_HALF), .C_SKEW_HALF(C_SKEW_HALF)
  ) u_rd (
    .clk(clk), .rst(rst), .k_only(k_only),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .beat0_d(b0_d), .beat0_en(b0_en), .beat1_d(b1_d), .beat1_en(b1_en),
    .arr0(arr0), .arr1(arr1),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );
endmodule

// File: tb/qdr_b2_sram_tb.sv
module qdr_b2_sram_tb;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int NL = 2;
  localparam int LW = DW / NL;
  localparam int NT = 1024;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d0;
    logic [NL-1:0] mn0;
    logic [DW-1:0] d1;
    logic [NL-1:0] mn1;
    logic [7:0]    req;
  } vec_t;

  // Stimulus per K cycle; expected read data follows from the lane rules.
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 6'd1, 18'h12345, 2'b00, 18'h0ABCD, 2'b00, 8'd2},  // R2 fill
    '{1'b1, 1'b0, 6'd2, 18'h3FFFF, 2'b00, 18'h00001, 2'b00, 8'd2},  // R2 fill
    '{1'b1, 1'b0, 6'd3, 18'h2AAAA, 2'b00, 18'h15555, 2'b00, 8'd6},  // fill
    '{1'b0, 1'b1, 6'd1, 18'h0,     2'b11, 18'h0,     2'b11, 8'd2},  // R2 read
    '{1'b0, 1'b1, 6'd2, 18'h0,     2'b11, 18'h0,     2'b11, 8'd7},  // R7 back-to-back
    '{1'b1, 1'b0, 6'd1, 18'h00000, 2'b10, 18'h3FFFF, 2'b01, 8'd3},  // R3 masked
    '{1'b0, 1'b1, 6'd1, 18'h0,     2'b11, 18'h0,     2'b11, 8'd3},  // R3 read
    '{1'b0, 1'b0, 6'd1, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, 8'd4},  // R4 deselected
    '{1'b0, 1'b1, 6'd1, 18'h0,     2'b11, 18'h0,     2'b11, 8'd4},  // R4 read
    '{1'b1, 1'b1, 6'd3, 18'h00000, 2'b01, 18'h3FFFF, 2'b10, 8'd6},  // R6 same cycle
    '{1'b0, 1'b0, 6'd3, 18'h0,     2'b11, 18'h0,     2'b11, 8'd5},  // R5 no read
    '{1'b0, 1'b1, 6'd3, 18'h0,     2'b11, 18'h0,     2'b11, 8'd6}   // R6 persisted
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          k_only = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic          rd_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NL-1:0] wmask_n = '1;
  logic [DW-1:0] rdata;
  logic          rdata_oe;
  logic          echo_clk;

  qdr_b2_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) u_dut (
    .clk(clk), .rst(rst), .k_only(k_only), .wr_sel_n(wr_sel_n),
    .rd_sel_n(rd_sel_n), .addr(addr), .wdata(wdata), .wmask_n(wmask_n),
    .rdata(rdata), .rdata_oe(rdata_oe), .echo_clk(echo_clk)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int total = 0;
  int bad = 0;
  int tk = 0;
  int lat = 3;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  logic [DW-1:0] mdl0 [1 << AW];
  logic [DW-1:0] mdl1 [1 << AW];
  logic          exp_oe  [NT];
  logic [DW-1:0] exp_q   [NT];
  int            exp_req [NT];

  always @(posedge clk) begin
    if (rst) tk <= 0;
    else     tk <= tk + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < NT; i++) begin
      exp_oe[i]  = 1'b0;
      exp_q[i]   = '0;
      exp_req[i] = 5;  // R5: no beat unless a read put one here
    end
  endtask

  // Monitor: edge just passed is tk-1.
  always @(negedge clk) begin
    if (mon_en && !rst && tk >= 1 && tk <= NT) begin
      int e;
      e = tk - 1;
      chk($sformatf("R%0d", exp_req[e]), $sformatf("oe@%0d", e),
          32'(rdata_oe), 32'(exp_oe[e]));
      if (exp_oe[e])
        chk($sformatf("R%0d", exp_req[e]), $sformatf("data@%0d", e),
            32'(rdata), 32'(exp_q[e]));
      chk("R10", $sformatf("echo@%0d", e), 32'(echo_clk),
          32'((e % 2) == (lat % 2)));  // R10
    end
  end

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
      input logic [DW-1:0] d, input logic [NL-1:0] mn);
    logic [DW-1:0] r;
    r = old;
    for (int l = 0; l < NL; l++)
      if (!mn[l]) r[l*LW +: LW] = d[l*LW +: LW];
    return r;
  endfunction

  // One K cycle; entered at the negedge before a K rising edge.
  task automatic kcyc(input vec_t v);
    int e;
    e = tk;
    wr_sel_n = ~v.wr;
    rd_sel_n = ~v.rd;
    addr     = v.a;
    wdata    = v.d0;
    wmask_n  = v.mn0;
    if (v.wr) begin
      mdl0[v.a] = merge(mdl0[v.a], v.d0, v.mn0);
      mdl1[v.a] = merge(mdl1[v.a], v.d1, v.mn1);
    end
    if (v.rd) begin
      exp_oe[e+lat]    = 1'b1;
      exp_q[e+lat]     = mdl0[v.a];
      exp_req[e+lat]   = int'(v.req);
      exp_oe[e+lat+1]  = 1'b1;
      exp_q[e+lat+1]   = mdl1[v.a];
      exp_req[e+lat+1] = int'(v.req);
      if (!exp_oe[e+lat+2]) exp_req[e+lat+2] = 8;  // R8 fall edge
    end
    @(negedge clk);
    wdata   = v.d1;
    wmask_n = v.mn1;
    @(negedge clk);
    wr_sel_n = 1'b1;
    rd_sel_n = 1'b1;
    wdata    = 18'h2D2D2;  // junk while idle
    wmask_n  = 2'b00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic ko);
    mon_en = 1'b0;
    rst    = 1'b1;
    k_only = ko;
    lat    = ko ? 3 : 5;
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", 32'(rdata_oe), 32'd0);
    chk("R1", "data in reset", 32'(rdata), 32'd0);
    clear_exp();
    rst    = 1'b0;
    mon_en = 1'b1;
  endtask

  initial begin
    clear_exp();
    do_reset(1'b1);
    idle(2);
    chk("R1", "oe after reset", 32'(rdata_oe), 32'd0);
    chk("R1", "data after reset", 32'(rdata), 32'd0);

    // Table walk in K-only mode: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) kcyc(VEC[i]);
    idle(5);

    // R1: reset lands before a pending read launches
    kcyc('{1'b0, 1'b1, 6'd1, 18'h0, 2'b11, 18'h0, 2'b11, 8'd1});
    mon_en = 1'b0;
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "oe with read cut by reset", 32'(rdata_oe), 32'd0);
    end
    clear_exp();
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1", "no stale beat after reset", 32'(rdata_oe), 32'd0);
    end

    // R9: separate output clock, launch delay grows to 5 half-cycles
    do_reset(1'b0);
    kcyc('{1'b1, 1'b0, 6'd4, 18'h0F0F0, 2'b00, 18'h30303, 2'b00, 8'd9});
    kcyc('{1'b0, 1'b1, 6'd4, 18'h0, 2'b11, 18'h0, 2'b11, 8'd9});
    kcyc('{1'b0, 1'b1, 6'd2, 18'h0, 2'b11, 18'h0, 2'b11, 8'd9});
    kcyc('{1'b1, 1'b1, 6'd4, 18'h3FFFF, 2'b10, 18'h00000, 2'b01, 8'd9});
    idle(6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule